// File: doc/BRIEF.md
# Age-Ordered Instruction Scheduler Queue

This block tracks instructions between dispatch and write-back. Each instruction carries an index that grows by one per dispatch, and the most significant index bit acts as a wrap bit so that age stays well defined after the counter rolls over. Each occupied slot is in one of three pools: waiting for operands, ready for issue, or issued and executing. Per-slot wakeup inputs promote waiting entries. A resource grant issues the oldest ready entry. A write-back completion frees an executing entry.

A dispatched instruction may be marked zero-latency. In that case it tries to go straight to the issued pool in its dispatch cycle. This works only when its operands are ready, the grant is present, and no older ready entry is pending. When the bypass cannot be taken, the instruction joins the ready pool. The surrounding pipeline reads `issue_idx` whenever `issue_valid` is high, and treats an issue as taken on any cycle where `grant` is also high.

Top module: `age_sched_queue`

## Requirements
- R1: While reset is held and right after it, every slot's state code is 0 (free), and `issue_valid`, `disp_stall` and `disp_dup` are low.
- R2: An accepted dispatch takes the lowest-numbered free slot. The slot's state becomes 2 (ready) if `disp_ops_rdy` is high and 1 (waiting) otherwise. The slot's `ent_idx` field becomes `disp_idx`. Slot k's state is `ent_state[2k+1:2k]` and its index is `ent_idx[IDX_W*k +: IDX_W]`.
- R3: A waiting slot becomes ready on the edge after a cycle in which both `wake_ops[k]` and `wake_mem[k]` are high. Either one alone leaves it waiting.
- R4: When any slot is ready, `issue_idx` is the index of the oldest ready slot. Index a is older than b when both have the same top bit and a's lower bits are smaller, or when the top bits differ and a's lower bits are larger.
- R5: A ready slot that is presented on `issue_idx` while `grant` is high becomes state 3 (executing) on the next edge. Without `grant` it stays ready.
- R6: `wb_valid` with `wb_idx` equal to an executing slot's index frees that slot on the next edge. A write-back that names a waiting or ready slot has no effect.
- R7: A zero-latency dispatch with ready operands, while no slot is ready and `grant` is high, is presented on `issue_idx` in the same cycle. Its slot enters state 3 directly.
- R8: A zero-latency dispatch that cannot bypass enters state 2. This happens when `grant` is low or an older entry is ready. In the second case the older entry is the one issued.
- R9: A dispatch whose index is already held by an occupied slot raises `disp_dup` in that cycle and is dropped, so no slot changes.
- R10: With every slot occupied, `disp_stall` is high. A dispatch in that cycle is dropped and is not offered for bypass issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_idx | input | IDX_W | Age index of the dispatched instruction, top bit is the wrap bit |
| disp_ops_rdy | input | 1 | All input operands already available |
| disp_zero_lat | input | 1 | Instruction requests same-cycle issue |
| disp_stall | output | 1 | No free slot, so dispatch is refused |
| disp_dup | output | 1 | Dispatched index already present, so dispatch is dropped |
| wake_ops | input | DEPTH | Per-slot register operands available |
| wake_mem | input | DEPTH | Per-slot memory dependencies met |
| grant | input | 1 | Execution resources accept the presented issue |
| wb_valid | input | 1 | Write-back completion |
| wb_idx | input | IDX_W | Index reaching write-back |
| issue_valid | output | 1 | An issue candidate is presented |
| issue_idx | output | IDX_W | Index of the issue candidate |
| ent_state | output | 2*DEPTH | Per-slot state code: 0 free, 1 waiting, 2 ready, 3 executing |
| ent_idx | output | IDX_W*DEPTH | Per-slot held index |

## Verification
The bench builds the queue with DEPTH=4 and IDX_W=4. With only four slots, a full queue can be reached in four dispatches, so stall behaviour is exercised directly. With three low index bits, the wrap bit flips after eight indices. This lets a short table of index pairs cover both age rules, including pairs where the younger index has wrapped past the older one. The small depth also keeps the choice between bypass and fallback, and the duplicate-index refusal, visible slot by slot.

// File: rtl/age_sched_queue.sv
module age_sched_queue #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  input  logic [IDX_W-1:0]       disp_idx,
  input  logic                   disp_ops_rdy,
  input  logic                   disp_zero_lat,
  output logic                   disp_stall,
  output logic                   disp_dup,
  input  logic [DEPTH-1:0]       wake_ops,
  input  logic [DEPTH-1:0]       wake_mem,
  input  logic                   grant,
  input  logic                   wb_valid,
  input  logic [IDX_W-1:0]       wb_idx,
  output logic                   issue_valid,
  output logic [IDX_W-1:0]       issue_idx,
  output logic [2*DEPTH-1:0]     ent_state,
  output logic [IDX_W*DEPTH-1:0] ent_idx
);
  localparam logic [1:0] FREE  = 2'd0;
  localparam logic [1:0] WAIT  = 2'd1;
  localparam logic [1:0] READY = 2'd2;
  localparam logic [1:0] EXEC  = 2'd3;
  localparam int LO = IDX_W - 1;

  logic [1:0]       st_q [DEPTH];
  logic [IDX_W-1:0] ix_q [DEPTH];

  logic [DEPTH-1:0] free_v, rdy_v, hit_v, win_v, alloc_v;
  logic [IDX_W-1:0] pick_ix;
  logic             any_rdy, accept, bypass, found;

  function automatic logic older(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b);
    if (a[IDX_W-1] == b[IDX_W-1]) return a[LO-1:0] < b[LO-1:0];
    return a[LO-1:0] > b[LO-1:0];
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_flags
    assign free_v[g] = (st_q[g] == FREE);
    assign rdy_v[g]  = (st_q[g] == READY);
    assign hit_v[g]  = (st_q[g] != FREE) && (ix_q[g] == disp_idx);
    assign ent_state[2*g +: 2]     = st_q[g];
    assign ent_idx[IDX_W*g +: IDX_W] = ix_q[g];
  end

  assign disp_stall = ~|free_v;
  assign disp_dup   = disp_valid & |hit_v;
  assign accept     = disp_valid & ~disp_stall & ~|hit_v;
  assign any_rdy    = |rdy_v;
  assign bypass     = accept & disp_zero_lat & disp_ops_rdy & ~any_rdy;
  assign issue_valid = any_rdy | bypass;
  assign issue_idx   = any_rdy ? pick_ix : disp_idx;

  always_comb begin
    alloc_v = '0;
    found   = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (free_v[i] && !found) begin
        alloc_v[i] = 1'b1;
        found      = 1'b1;
      end
  end

  always_comb begin
    pick_ix = '0;
    for (int i = 0; i < DEPTH; i++) begin
      win_v[i] = rdy_v[i];
      for (int j = 0; j < DEPTH; j++)
        if (j != i && rdy_v[j] && older(ix_q[j], ix_q[i])) win_v[i] = 1'b0;
      if (win_v[i]) pick_ix = pick_ix | ix_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i] <= FREE;
        ix_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (st_q[i] == WAIT && wake_ops[i] && wake_mem[i]) st_q[i] <= READY;
        if (rdy_v[i] && win_v[i] && grant) st_q[i] <= EXEC;
        if (st_q[i] == EXEC && wb_valid && ix_q[i] == wb_idx) st_q[i] <= FREE;
        if (accept && alloc_v[i]) begin
          ix_q[i] <= disp_idx;
          if (bypass && grant)    st_q[i] <= EXEC;
          else if (disp_ops_rdy)  st_q[i] <= READY;
          else                    st_q[i] <= WAIT;
        end
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    // R3
    promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == WAIT && wake_ops[g] && wake_mem[g]) |=> st_q[g] == READY);
    // R5
    issue_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == READY && issue_valid && grant && issue_idx == ix_q[g]) |=> st_q[g] == EXEC);
    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == READY && !grant) |=> st_q[g] == READY);
    // R6
    wb_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == EXEC && wb_valid && wb_idx == ix_q[g]) |=> st_q[g] == FREE);
  end

  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |=> $countones(free_v) <= 1);

  // R9
  always @(posedge clk)
    if (rst_n)
      for (int i = 0; i < DEPTH; i++)
        for (int j = i + 1; j < DEPTH; j++)
          uniq_idx_chk: assert (!(st_q[i] != FREE && st_q[j] != FREE && ix_q[i] == ix_q[j]));
endmodule

// File: tb/sim_age_sched_queue.sv
module sim_age_sched_queue;
  localparam int DEPTH = 4;
  localparam int IDX_W = 4;

  logic clk = 0, rst_n = 0;
  logic disp_valid, disp_ops_rdy, disp_zero_lat, grant, wb_valid;
  logic [IDX_W-1:0] disp_idx, wb_idx;
  logic [DEPTH-1:0] wake_ops, wake_mem;
  logic disp_stall, disp_dup, issue_valid;
  logic [IDX_W-1:0] issue_idx;
  logic [2*DEPTH-1:0] ent_state;
  logic [IDX_W*DEPTH-1:0] ent_idx;

  int checks = 0, fails = 0;

  localparam int VA [4] = '{7, 9, 14, 3};
  localparam int VB [4] = '{8, 14, 1, 1};
  localparam int VE [4] = '{7, 9, 14, 1};

  always #10 clk = ~clk;

  age_sched_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_idx(disp_idx),
    .disp_ops_rdy(disp_ops_rdy), .disp_zero_lat(disp_zero_lat),
    .disp_stall(disp_stall), .disp_dup(disp_dup), .wake_ops(wake_ops),
    .wake_mem(wake_mem), .grant(grant), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .issue_valid(issue_valid), .issue_idx(issue_idx), .ent_state(ent_state),
    .ent_idx(ent_idx));

  function automatic int st(int k);
    return int'(ent_state[2*k +: 2]);
  endfunction
  function automatic int ix(int k);
    return int'(ent_idx[IDX_W*k +: IDX_W]);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_idx = '0; disp_ops_rdy = 0; disp_zero_lat = 0;
    wake_ops = '0; wake_mem = '0; grant = 0; wb_valid = 0; wb_idx = '0;
  endtask

  task automatic disp(int id, bit ops, bit zl, bit gr);
    idle();
    disp_valid = 1; disp_idx = IDX_W'(id); disp_ops_rdy = ops;
    disp_zero_lat = zl; grant = gr;
  endtask

  task automatic wb(int id);
    idle(); wb_valid = 1; wb_idx = IDX_W'(id);
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    for (int k = 0; k < DEPTH; k++) check("R1 state", st(k), 0);
    check("R1 issue_valid", int'(issue_valid), 0);
    check("R1 stall", int'(disp_stall), 0);
    check("R1 dup", int'(disp_dup), 0);
    step();

    for (int r = 0; r < 4; r++) begin
      disp(VA[r], 1, 0, 0); step();
      disp(VB[r], 1, 0, 0); step();
      grant = 1; #1;
      check("R4 oldest", int'(issue_idx), VE[r]);
      step();
      grant = 1; #1;
      check("R4 second", int'(issue_idx), (VE[r] == VA[r]) ? VB[r] : VA[r]);
      step();
      wb(VA[r]); step();
      wb(VB[r]); step();
      check("R6 free slot0", st(0), 0);
      check("R6 free slot1", st(1), 0);
    end

    disp(5, 0, 0, 0); step();
    check("R2 waiting", st(0), 1);
    check("R2 index", ix(0), 5);
    disp(6, 1, 0, 0); step();
    check("R2 ready", st(1), 2);
    wake_ops = 4'b0001; #1;
    check("R4 single ready", int'(issue_idx), 6);
    step();
    check("R3 ops only stays", st(0), 1);
    check("R5 no grant stays", st(1), 2);
    wake_mem = 4'b0001; step();
    check("R3 mem only stays", st(0), 1);
    wake_ops = 4'b0001; wake_mem = 4'b0001; step();
    check("R3 promoted", st(0), 2);
    grant = 1; #1;
    check("R4 older 5", int'(issue_idx), 5);
    step();
    check("R5 executing", st(0), 3);
    check("R5 other ready", st(1), 2);
    wb(6); step();
    check("R6 wb ignored on ready", st(1), 2);
    wb(5); grant = 1; step();
    check("R6 freed", st(0), 0);
    check("R5 issued", st(1), 3);
    wb(6); step();

    disp(9, 1, 1, 1); #1;
    check("R7 bypass valid", int'(issue_valid), 1);
    check("R7 bypass idx", int'(issue_idx), 9);
    step();
    check("R7 slot exec", st(0), 3);
    disp(10, 1, 1, 0); step();
    check("R8 no grant falls back", st(1), 2);
    disp(11, 1, 1, 1); #1;
    check("R8 older wins", int'(issue_idx), 10);
    step();
    check("R8 older issued", st(1), 3);
    check("R8 zl to ready", st(2), 2);
    grant = 1; step();
    wb(9); step();
    wb(10); step();
    wb(11); step();
    check("R6 all free", int'(ent_state), 0);

    disp(4, 0, 0, 0); step();
    disp(4, 1, 0, 0); #1;
    check("R9 dup flag", int'(disp_dup), 1);
    step();
    check("R9 slot0 unchanged", st(0), 1);
    check("R9 slot1 untouched", st(1), 0);
    wake_ops = 4'b0001; wake_mem = 4'b0001; step();
    grant = 1; step();
    wb(4); step();

    disp(1, 0, 0, 0); step();
    disp(2, 0, 0, 0); step();
    disp(3, 0, 0, 0); step();
    disp(5, 0, 0, 0); step();
    #1;
    check("R10 stall", int'(disp_stall), 1);
    disp(7, 1, 1, 1); #1;
    check("R10 no bypass", int'(issue_valid), 0);
    step();
    check("R10 slot0", ix(0), 1);
    check("R10 slot1", ix(1), 2);
    check("R10 slot2", ix(2), 3);
    check("R10 slot3", ix(3), 5);
    for (int k = 0; k < DEPTH; k++) check("R10 state", st(k), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule